// File: doc/BRIEF.md
# Strided Vector Load Address Sequencer

This block expands one load command into a run of element loads. The command names a destination register N, a base register M with its bank, a signed 12-bit immediate, the base address value read from M, and the vector length configured for N. Element i goes to register N+i, and each element has its own memory address.

A small table of two offset entries decides how the addresses advance. A set-offset command fills one entry with a register number, a bank bit, a stride-mode bit and an XLEN-wide offset amount. When a load is accepted, M is looked up in the table. The first matching entry adds its offset amount to the base. In offset mode that entry also turns the immediate into the distance between elements. Otherwise the elements are contiguous words.

Memory requests use a valid/ready handshake, and only one request is outstanding at a time. Each response is forwarded as a register write. A one-cycle done pulse closes the run.

Top module: `strided_vload_seq`

## Requirements
- R1: After reset the block is idle: cmd_ready_o is high, mem_req_valid_o, rf_we_o and done_o are low, and both offset entries are empty, so no load matches them.
- R2: A set-offset command (set_valid_i high while the clock rises) writes the entry chosen by set_slot_i with set_rnum_i, set_bank_i, set_mode_i (1 = offset mode, 0 = unit mode) and set_amt_i.
- R3: A load matches an entry only if that entry has been written and holds both the same register number and the same bank as the load's base register. Entry 0 is tried before entry 1, and the first match is used.
- R4: With a match in offset mode, element i is requested at base + amount + i*imm, where imm is cmd_imm_i sign-extended to XLEN. The sum wraps modulo 2^XLEN.
- R5: With a match in unit mode, element i is requested at base + amount + 4*i. With no match it is requested at base + 4*i.
- R6: The number of elements is cmd_vlen_i, and a length of 0 is treated as 1. Element i is written to register (N+i) mod 32 with the data of its memory response, in the cycle that response arrives.
- R7: A request holds its address until mem_req_ready_i is seen. After a handshake, no new request is raised until the response for that element has been written.
- R8: done_o is high for exactly one cycle, in the cycle after the last element's write. cmd_ready_o is low from acceptance through that cycle and high again in the next one.
- R9: A set-offset command that arrives in the same cycle as the load's acceptance, or while the load is running, does not change that load. It takes effect for later loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_valid_i | input | 1 | Set-offset command strobe |
| set_slot_i | input | 1 | Offset entry to write |
| set_rnum_i | input | 5 | Register number stored in the entry |
| set_bank_i | input | 1 | Register bank of the entry (0 integer, 1 float) |
| set_mode_i | input | 1 | 1 = immediate is the stride, 0 = contiguous |
| set_amt_i | input | XLEN | Offset amount |
| cmd_valid_i | input | 1 | Load command valid |
| cmd_ready_o | output | 1 | Block idle, command accepted |
| cmd_dst_i | input | 5 | First destination register N |
| cmd_base_rnum_i | input | 5 | Base register number M |
| cmd_base_bank_i | input | 1 | Bank of M |
| cmd_imm_i | input | 12 | Load immediate, signed |
| cmd_base_addr_i | input | XLEN | Value of register M |
| cmd_vlen_i | input | 5 | Vector length of N |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_addr_o | output | XLEN | Element address |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_data_i | input | XLEN | Memory response data |
| rf_we_o | output | 1 | Register write enable |
| rf_idx_o | output | 5 | Register written |
| rf_data_o | output | XLEN | Data written |
| done_o | output | 1 | Load sequence finished |

## Verification
A set-offset command can arrive in the same cycle as a load is accepted. It can also arrive while a load is still stepping through its elements. The bench drives both cases. First it drives a set-offset on the exact cycle a load is presented, which gives that entry its first contents for the load's base register. Later it rewrites the same entry while a six-element load is still running. The reference model resolves every load against the table as it stood before that clock edge. The result is judged by comparing every request address and register write against the model, and then by checking that the next load does use the new entry.

// File: rtl/svl_pkg.sv
package svl_pkg;
  localparam int unsigned RNUM_W = 5;
  typedef logic [RNUM_W-1:0] rnum_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic  vld;
    rnum_t rnum;
    logic  bank;
    logic  off_mode;
  } ent_tag_t;
endpackage

// File: rtl/svl_offset_table.sv
module svl_offset_table
  import svl_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned N_ENT  = 2,
  localparam int unsigned SLOT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_valid_i,
  input  logic [SLOT_W-1:0] set_slot_i,
  input  rnum_t             set_rnum_i,
  input  logic              set_bank_i,
  input  logic              set_mode_i,
  input  logic [XLEN-1:0]   set_amt_i,
  input  rnum_t             look_rnum_i,
  input  logic              look_bank_i,
  output logic              hit_o,
  output logic              hit_off_mode_o,
  output logic [XLEN-1:0]   hit_amt_o
);
  ent_tag_t         tag_q [N_ENT];
  logic [XLEN-1:0]  amt_q [N_ENT];
  logic [N_ENT-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_ENT; e++) begin
        tag_q[e] <= '0;
        amt_q[e] <= '0;
      end
    end else if (set_valid_i) begin
      for (int e = 0; e < N_ENT; e++) begin
        if (set_slot_i == SLOT_W'(e)) begin
          tag_q[e] <= '{vld: 1'b1, rnum: set_rnum_i, bank: set_bank_i, off_mode: set_mode_i};
          amt_q[e] <= set_amt_i;
        end
      end
    end
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_match
    assign match[e] = tag_q[e].vld && (tag_q[e].rnum == look_rnum_i)
                      && (tag_q[e].bank == look_bank_i);
  end

  // lowest index wins: scan downward, last hit assigned stays
  always_comb begin
    hit_o          = 1'b0;
    hit_off_mode_o = 1'b0;
    hit_amt_o      = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (match[e]) begin
        hit_o          = 1'b1;
        hit_off_mode_o = tag_q[e].off_mode;
        hit_amt_o      = amt_q[e];
      end
    end
  end
endmodule

// File: rtl/svl_addr_gen.sv
module svl_addr_gen #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IMM_W      = 12,
  parameter int unsigned ELEM_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  offs_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             off_mode_i,
  input  logic             adv_i,
  output logic [XLEN-1:0]  addr_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] addr_q, step_q, step_d;

  assign step_d = off_mode_i ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i} : XLEN'(ELEM_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      step_q <= '0;
    end else if (start_i) begin
      addr_q <= base_i + offs_i;
      step_q <= step_d;
    end else if (adv_i) begin
      addr_q <= addr_q + step_q;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/svl_elem_ctrl.sv
module svl_elem_ctrl
  import svl_pkg::*;
#(
  parameter int unsigned VL_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  output logic            start_o,
  input  rnum_t           dst_i,
  input  logic [VL_W-1:0] vlen_i,
  output logic            req_valid_o,
  input  logic            req_ready_i,
  output logic            adv_o,
  input  logic            rsp_valid_i,
  output logic            we_o,
  output rnum_t           idx_o,
  output logic            done_o
);
  seq_state_e      st_q, st_d;
  logic [VL_W-1:0] rem_q;
  rnum_t           idx_q;
  logic            last;

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign start_o     = cmd_ready_o && cmd_valid_i;
  assign req_valid_o = (st_q == ST_REQ);
  assign adv_o       = req_valid_o && req_ready_i;
  assign we_o        = (st_q == ST_WAIT) && rsp_valid_i;
  assign idx_o       = idx_q;
  assign done_o      = (st_q == ST_DONE);
  assign last        = (rem_q == VL_W'(1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_o) st_d = ST_REQ;
      ST_REQ:  if (adv_o) st_d = ST_WAIT;
      ST_WAIT: if (we_o) st_d = last ? ST_DONE : ST_REQ;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_o) begin
        rem_q <= (vlen_i == '0) ? VL_W'(1) : vlen_i;
        idx_q <= dst_i;
      end else if (we_o) begin
        rem_q <= rem_q - VL_W'(1);
        idx_q <= idx_q + rnum_t'(1);
      end
    end
  end
endmodule

// File: rtl/strided_vload_seq.sv
module strided_vload_seq
  import svl_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IMM_W      = 12,
  parameter int unsigned VL_W       = 5,
  parameter int unsigned N_ENT      = 2,
  parameter int unsigned ELEM_BYTES = 4,
  localparam int unsigned SLOT_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_valid_i,
  input  logic [SLOT_W-1:0] set_slot_i,
  input  logic [4:0]        set_rnum_i,
  input  logic              set_bank_i,
  input  logic              set_mode_i,
  input  logic [XLEN-1:0]   set_amt_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [4:0]        cmd_dst_i,
  input  logic [4:0]        cmd_base_rnum_i,
  input  logic              cmd_base_bank_i,
  input  logic [IMM_W-1:0]  cmd_imm_i,
  input  logic [XLEN-1:0]   cmd_base_addr_i,
  input  logic [VL_W-1:0]   cmd_vlen_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [XLEN-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [XLEN-1:0]   mem_rsp_data_i,
  output logic              rf_we_o,
  output logic [4:0]        rf_idx_o,
  output logic [XLEN-1:0]   rf_data_o,
  output logic              done_o
);
  logic            hit, hit_off_mode, start, adv;
  logic [XLEN-1:0] hit_amt;

  svl_offset_table #(.XLEN(XLEN), .N_ENT(N_ENT)) u_tbl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .set_valid_i    (set_valid_i),
    .set_slot_i     (set_slot_i),
    .set_rnum_i     (set_rnum_i),
    .set_bank_i     (set_bank_i),
    .set_mode_i     (set_mode_i),
    .set_amt_i      (set_amt_i),
    .look_rnum_i    (cmd_base_rnum_i),
    .look_bank_i    (cmd_base_bank_i),
    .hit_o          (hit),
    .hit_off_mode_o (hit_off_mode),
    .hit_amt_o      (hit_amt)
  );

  svl_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .ELEM_BYTES(ELEM_BYTES)) u_agen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .base_i     (cmd_base_addr_i),
    .offs_i     (hit_amt),
    .imm_i      (cmd_imm_i),
    .off_mode_i (hit && hit_off_mode),
    .adv_i      (adv),
    .addr_o     (mem_req_addr_o)
  );

  svl_elem_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .start_o     (start),
    .dst_i       (cmd_dst_i),
    .vlen_i      (cmd_vlen_i),
    .req_valid_o (mem_req_valid_o),
    .req_ready_i (mem_req_ready_i),
    .adv_o       (adv),
    .rsp_valid_i (mem_rsp_valid_i),
    .we_o        (rf_we_o),
    .idx_o       (rf_idx_o),
    .done_o      (done_o)
  );

  assign rf_data_o = mem_rsp_data_i;
endmodule

// File: rtl/svl_checks.sv
module svl_checks #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_ready_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [XLEN-1:0] mem_req_addr_o,
  input logic            rf_we_o,
  input logic            done_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !mem_req_valid_o && !rf_we_o && !done_o);

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  p_one_outstanding_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o);

  p_write_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> !mem_req_valid_o);

  p_done_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rf_we_o));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && cmd_ready_o);
endmodule

bind strided_vload_seq svl_checks #(.XLEN(XLEN)) u_svl_checks (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_ready_o     (cmd_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .rf_we_o         (rf_we_o),
  .done_o          (done_o)
);

// File: tb/strided_vload_seq_bench.sv
module strided_vload_seq_bench;
  localparam int XLEN = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        set_valid_i = 1'b0;
  logic [0:0]  set_slot_i = '0;
  logic [4:0]  set_rnum_i = '0;
  logic        set_bank_i = 1'b0;
  logic        set_mode_i = 1'b0;
  logic [31:0] set_amt_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [4:0]  cmd_dst_i = '0;
  logic [4:0]  cmd_base_rnum_i = '0;
  logic        cmd_base_bank_i = 1'b0;
  logic [11:0] cmd_imm_i = '0;
  logic [31:0] cmd_base_addr_i = '0;
  logic [4:0]  cmd_vlen_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        rf_we_o;
  logic [4:0]  rf_idx_o;
  logic [31:0] rf_data_o;
  logic        done_o;

  always #2 clk_i = ~clk_i;

  strided_vload_seq u_strided_vload_seq (.*);

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  bit          m_vld [2];
  logic [4:0]  m_rn  [2];
  bit          m_bank[2];
  bit          m_mode[2];
  logic [31:0] m_amt [2];
  logic [31:0] q_addr[$];
  logic [4:0]  q_idx[$];
  logic [31:0] q_wd[$];
  bit          busy = 0, done_exp = 0, pend = 0;
  int          pend_wait = 0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] mem_fn(logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9bdf;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // memory model: drive ready and responses
  always @(negedge clk_i) begin
    cyc++;
    mem_rsp_valid_i = 1'b0;
    if (pend) begin
      if (pend_wait == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = mem_fn(pend_addr);
        pend = 0;
      end else pend_wait--;
    end
    mem_req_ready_i = (cyc % 3) != 1;
  end

  // cycle-by-cycle comparison
  always begin
    @(negedge clk_i);
    #1;
    if (cyc > 20000) begin
      chk(0, "R8", "watchdog expired", cyc, 0);
      summary();
    end
    if (rst_ni) begin
      chk(cmd_ready_o == !busy, "R8", "cmd_ready", cmd_ready_o, !busy);
      chk(done_o == done_exp, "R8", "done", done_o, done_exp);
      if (done_exp) busy = 0;
      done_exp = 0;
      if (cmd_valid_i && cmd_ready_o) busy = 1;
      chk(busy || cmd_valid_i || (!mem_req_valid_o && !rf_we_o), "R1", "idle activity",
          {mem_req_valid_o, rf_we_o}, 0);
      chk(!(mem_req_valid_o && (pend || mem_rsp_valid_i)), "R7", "request while outstanding",
          mem_req_valid_o, 0);
      if (mem_req_valid_o) begin
        if (q_addr.size() == 0) chk(0, tag, "unexpected request", mem_req_addr_o, 0);
        else chk(mem_req_addr_o == q_addr[0], tag, "address", mem_req_addr_o, q_addr[0]);
        if (mem_req_ready_i) begin
          pend = 1;
          pend_addr = mem_req_addr_o;
          pend_wait = cyc % 2;
          if (q_addr.size() != 0) void'(q_addr.pop_front());
        end
      end
      if (mem_rsp_valid_i) chk(rf_we_o, "R6", "response not written", rf_we_o, 1);
      if (rf_we_o) begin
        if (q_idx.size() == 0) chk(0, "R6", "unexpected write", rf_idx_o, 0);
        else begin
          chk(rf_idx_o == q_idx[0], "R6", "write index", rf_idx_o, q_idx[0]);
          chk(rf_data_o == q_wd[0], "R6", "write data", rf_data_o, q_wd[0]);
          void'(q_idx.pop_front());
          void'(q_wd.pop_front());
          if (q_idx.size() == 0) done_exp = 1;
        end
      end
    end
  end

  task automatic drive_load(logic [4:0] dst, logic [4:0] mrn, bit mb, logic [11:0] imm,
                            logic [31:0] base, logic [4:0] vlen);
    bit          md = 0;
    logic [31:0] am = '0, step, a;
    int          n;
    for (int e = 1; e >= 0; e--)
      if (m_vld[e] && m_rn[e] == mrn && m_bank[e] == mb) begin
        md = m_mode[e];
        am = m_amt[e];
      end
    step = md ? {{20{imm[11]}}, imm} : 32'd4;
    n = (vlen == 0) ? 1 : int'(vlen);
    for (int i = 0; i < n; i++) begin
      a = base + am + step * 32'(i);
      q_addr.push_back(a);
      q_idx.push_back(5'(dst + 5'(i)));
      q_wd.push_back(mem_fn(a));
    end
    cmd_valid_i = 1; cmd_dst_i = dst; cmd_base_rnum_i = mrn; cmd_base_bank_i = mb;
    cmd_imm_i = imm; cmd_base_addr_i = base; cmd_vlen_i = vlen;
  endtask

  task automatic drive_set(bit slot, logic [4:0] rn, bit bank, bit mode, logic [31:0] amt);
    set_valid_i = 1; set_slot_i = slot; set_rnum_i = rn; set_bank_i = bank;
    set_mode_i = mode; set_amt_i = amt;
    m_vld[slot] = 1; m_rn[slot] = rn; m_bank[slot] = bank; m_mode[slot] = mode; m_amt[slot] = amt;
  endtask

  task automatic step();
    @(negedge clk_i);
    cmd_valid_i = 0;
    set_valid_i = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (busy || q_idx.size() != 0);
  endtask

  task automatic load(logic [4:0] dst, logic [4:0] mrn, bit mb, logic [11:0] imm,
                      logic [31:0] base, logic [4:0] vlen);
    @(negedge clk_i);
    drive_load(dst, mrn, mb, imm, base, vlen);
    step();
    wait_idle();
  endtask

  task automatic set_only(bit slot, logic [4:0] rn, bit bank, bit mode, logic [31:0] amt);
    @(negedge clk_i);
    drive_set(slot, rn, bank, mode, amt);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    #1;
    chk(cmd_ready_o && !mem_req_valid_o && !rf_we_o && !done_o, "R1", "reset state",
        {cmd_ready_o, mem_req_valid_o, rf_we_o, done_o}, 4'b1000);

    // R1 / R5: empty table, contiguous words from 0x1230
    tag = "R5";
    load(5'd0, 5'd2, 0, 12'd12, 32'h1230, 5'd4);

    // R2 / R4: offset mode, imm as stride
    tag = "R4";
    set_only(0, 5'd7, 0, 1, 32'h100);
    load(5'd8, 5'd7, 0, 12'd12, 32'h2000, 5'd3);
    load(5'd3, 5'd7, 0, 12'hFF8, 32'h3000, 5'd4);
    load(5'd1, 5'd7, 0, 12'h800, 32'hFFFF_FF00, 5'd3);

    // R2 / R5: unit mode with offset amount
    tag = "R5";
    set_only(1, 5'd9, 0, 0, 32'h40);
    load(5'd4, 5'd9, 0, 12'd100, 32'h4000, 5'd2);

    // R3: priority and bank match
    tag = "R3";
    set_only(1, 5'd7, 0, 0, 32'h999);
    load(5'd10, 5'd7, 0, 12'd20, 32'h5000, 5'd3);
    set_only(1, 5'd9, 1, 0, 32'h70);
    load(5'd11, 5'd9, 0, 12'd20, 32'h6000, 5'd2);
    load(5'd12, 5'd9, 1, 12'd20, 32'h6000, 5'd2);

    // R6: zero length, register wrap, long run
    tag = "R6";
    load(5'd5, 5'd3, 0, 12'd0, 32'h7000, 5'd0);
    load(5'd30, 5'd3, 0, 12'd0, 32'h7100, 5'd4);
    load(5'd0, 5'd3, 0, 12'd0, 32'h8000, 5'd31);

    // R9: set-offset in the acceptance cycle, then during a run
    tag = "R9";
    @(negedge clk_i);
    drive_load(5'd14, 5'd12, 0, 12'd8, 32'h9000, 5'd3);
    drive_set(0, 5'd12, 0, 1, 32'h800);
    step();
    wait_idle();
    @(negedge clk_i);
    drive_load(5'd15, 5'd12, 0, 12'd16, 32'hA000, 5'd6);
    step();
    drive_set(0, 5'd12, 0, 0, 32'h10);
    step();
    wait_idle();
    load(5'd20, 5'd12, 0, 12'd16, 32'hB000, 5'd3);

    repeat (4) @(negedge clk_i);
    summary();
  end
endmodule